// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Output-Bus Gating

This block is the serial test port of a memory device. A sixteen-state controller runs on the test clock `tck`. The mode input `tms` steers it, and the asynchronous `trst_n` resets it. A three-bit instruction register picks which data register is connected between `tdi` and `tdo`: a 32-bit identification word, a one-flop bypass stage, or a boundary chain with one cell per device pin. The boundary chain captures the parallel pin values and shifts them out least significant bit first. At the same moment it shifts in a new pattern, and it copies that pattern into parallel preload latches.

One boundary cell, set by parameter (`OE_CELL`, default 47), acts as the gate of the output bus. While the external-test instruction is active, its latched value alone decides whether the output drivers are enabled. That latch comes out of reset at 1. The high-impedance sampling instruction turns the output bus off until another instruction is installed.

All pins are plain level signals sampled on `tck`. No stream handshake is involved, so there is no back-pressure. The test host paces every transfer with `tck` and `tms`. `tdo` is meaningful only while `tdo_oe` is high.

Top module: `scan_port_top`

## Requirements
- R1: The controller follows the standard 16-state TMS graph on rising `tck`. Five consecutive TMS-high clocks reach Test-Logic-Reset from any state, and `trst_n` low forces that state asynchronously.
- R2: In reset and in Test-Logic-Reset, the active instruction becomes IDCODE (001). All preload latches clear, except cell `OE_CELL`, which is set to 1.
- R3: Under IDCODE, Capture-DR loads the 32-bit identification word with bit 0 forced to 1, and Shift-DR sends it out LSB first.
- R4: Capture-IR loads 3'b001 into the instruction shift stage, and this value shifts out LSB first. The active instruction changes only in Update-IR.
- R5: BYPASS (111) selects a single flop that Capture-DR clears. The first bit shifted out is therefore 0, and each later bit is TDI delayed by one clock.
- R6: The reserved opcodes 011, 101 and 110 behave exactly like BYPASS.
- R7: Under SAMPLE/PRELOAD (100), EXTEST (000) or SAMPLE Z (010), Capture-DR loads `pin_capture`, and Shift-DR shifts it out LSB first while TDI enters at the top cell.
- R8: Update-DR copies the boundary shift stage into `preload_out`, but only under SAMPLE/PRELOAD or EXTEST. In every other case the latches hold.
- R9: Under EXTEST, `out_enable` equals the latched value of cell `OE_CELL`, with 1 meaning drive and 0 meaning high impedance.
- R10: Under SAMPLE Z, `out_enable` is 0 until a different instruction is installed in Update-IR.
- R11: Under any instruction other than EXTEST and SAMPLE Z, `out_enable` is 1.
- R12: `tdo` and `tdo_oe` update on falling `tck`. `tdo_oe` is high only after a falling edge spent in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | High when tdo carries shift data |
| pin_capture | input | BSR_LEN | Parallel pin values sampled in Capture-DR |
| preload_out | output | BSR_LEN | Latched boundary pattern toward the pins |
| out_enable | output | 1 | Output-bus driver enable |

## Verification
Assertions check five behaviours on every clock:
- the controller holds in Test-Logic-Reset while TMS is high, and leaves Update-DR correctly;
- the instruction and the preload latches change only in their update states or in reset, and reset reloads them;
- the bypass flop clears on capture;
- `tdo_oe` tracks the shift states;
- `out_enable` is low only under EXTEST or SAMPLE Z.

Only the bench scenarios can show the data-path results. These are the identification word, the captured pin snapshot arriving in order, the one-clock bypass delay, the behaviour of the reserved opcodes, and the gate cell being written under both SAMPLE/PRELOAD and EXTEST and then returning to 1 after a TMS-driven reset.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    S_TLR, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UP_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UP_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_t;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;
endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_IDLE;
      S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nxt = tms ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nxt = tms ? S_UP_IR  : S_SH_IR;
      S_UP_IR:  nxt = tms ? S_SEL_DR : S_IDLE;
      default:  nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nxt;

  AST_TLR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR && tms) |=> state == S_TLR); // R1
  AST_UPDR_EXIT: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UP_DR) |=> (state == S_IDLE || state == S_SEL_DR)); // R1
endmodule

// File: rtl/scan_instr.sv
module scan_instr
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_cur,
  output logic            ir_sout,
  output dr_sel_t         dr_sel,
  output logic            is_extest,
  output logic            is_samplez,
  output logic            bsr_upd_en
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir_sh  <= OP_IDCODE;
      ir_cur <= OP_IDCODE;
    end else if (state == S_TLR) begin
      ir_sh  <= OP_IDCODE;
      ir_cur <= OP_IDCODE;
    end else begin
      if (state == S_CAP_IR)     ir_sh <= IR_CAPTURE;
      else if (state == S_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (state == S_UP_IR)      ir_cur <= ir_sh;
    end

  assign ir_sout = ir_sh[0];

  always_comb begin
    unique case (ir_cur)
      OP_IDCODE:                         dr_sel = DR_ID;
      OP_EXTEST, OP_SAMPLE, OP_SAMPLE_Z: dr_sel = DR_BSR;
      default:                           dr_sel = DR_BYP;
    endcase
  end

  assign is_extest  = (ir_cur == OP_EXTEST);
  assign is_samplez = (ir_cur == OP_SAMPLE_Z);
  assign bsr_upd_en = (ir_cur == OP_EXTEST) || (ir_cur == OP_SAMPLE);

  AST_IR_RESET_ID: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> ir_cur == OP_IDCODE); // R2
  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UP_IR && state != S_TLR) |=> $stable(ir_cur)); // R4
endmodule

// File: rtl/scan_bsr.sv
module scan_bsr
  import scan_pkg::*;
#(
  parameter int LEN     = 48,
  parameter int OE_CELL = 47
) (
  input  logic           tck,
  input  logic           trst_n,
  input  tap_state_t     state,
  input  logic           sel,
  input  logic           upd_en,
  input  logic           is_extest,
  input  logic           is_samplez,
  input  logic           tdi,
  input  logic [LEN-1:0] pins,
  output logic           sout,
  output logic [LEN-1:0] preload,
  output logic           out_enable
);
  localparam logic [LEN-1:0] PL_RESET = LEN'(1) << OE_CELL;

  logic [LEN-1:0] sh;
  logic [LEN-1:0] chain_in;

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic sh_q, pl_q;
    if (i == LEN-1) begin : g_head
      assign chain_in[i] = tdi;
    end else begin : g_body
      assign chain_in[i] = sh[i+1];
    end

    always_ff @(posedge tck or negedge trst_n)
      if (!trst_n) begin
        sh_q <= 1'b0;
        pl_q <= PL_RESET[i];
      end else if (state == S_TLR) begin
        pl_q <= PL_RESET[i];
      end else begin
        if (sel && state == S_CAP_DR)     sh_q <= pins[i];
        else if (sel && state == S_SH_DR) sh_q <= chain_in[i];
        if (upd_en && state == S_UP_DR)   pl_q <= sh_q;
      end

    assign sh[i]      = sh_q;
    assign preload[i] = pl_q;
  end

  assign sout       = sh[0];
  assign out_enable = is_samplez ? 1'b0 : (is_extest ? preload[OE_CELL] : 1'b1);

  AST_PL_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UP_DR && state != S_TLR) |=> $stable(preload)); // R8
  AST_PL_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> preload == PL_RESET); // R2
endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_pkg::*;
#(
  parameter int          BSR_LEN  = 48,
  parameter int          OE_CELL  = 47,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4E
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_capture,
  output logic [BSR_LEN-1:0] preload_out,
  output logic               out_enable
);
  localparam int          ID_W   = 32;
  localparam logic [ID_W-1:0] ID_EFF = ID_VALUE | ID_W'(1);

  tap_state_t      state;
  logic [IR_W-1:0] ir_cur;
  logic            ir_sout, is_extest, is_samplez, bsr_upd_en, bsr_sout;
  dr_sel_t         dr_sel;
  logic [ID_W-1:0] id_sh;
  logic            byp_q;
  logic            sout;

  scan_tap_fsm u_fsm (.tck, .trst_n, .tms, .state);

  scan_instr u_ir (
    .tck, .trst_n, .state, .tdi, .ir_cur, .ir_sout, .dr_sel,
    .is_extest, .is_samplez, .bsr_upd_en
  );

  scan_bsr #(.LEN(BSR_LEN), .OE_CELL(OE_CELL)) u_bsr (
    .tck, .trst_n, .state, .sel(dr_sel == DR_BSR), .upd_en(bsr_upd_en),
    .is_extest, .is_samplez, .tdi, .pins(pin_capture), .sout(bsr_sout),
    .preload(preload_out), .out_enable
  );

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      id_sh <= '0;
      byp_q <= 1'b0;
    end else begin
      if (dr_sel == DR_ID && state == S_CAP_DR)     id_sh <= ID_EFF;
      else if (dr_sel == DR_ID && state == S_SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
      if (dr_sel == DR_BYP && state == S_CAP_DR)     byp_q <= 1'b0;
      else if (dr_sel == DR_BYP && state == S_SH_DR) byp_q <= tdi;
    end

  always_comb begin
    if (state == S_SH_IR) sout = ir_sout;
    else begin
      unique case (dr_sel)
        DR_ID:   sout = id_sh[0];
        DR_BSR:  sout = bsr_sout;
        default: sout = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= sout;
      tdo_oe <= (state == S_SH_DR) || (state == S_SH_IR);
    end

  AST_TDO_OE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == S_SH_DR || state == S_SH_IR)); // R12
  AST_OE_LOW_CAUSE: assert property (@(posedge tck) disable iff (!trst_n)
    !out_enable |-> (ir_cur == OP_EXTEST || ir_cur == OP_SAMPLE_Z)); // R10
  AST_BYP_CLEAR: assert property (@(posedge tck) disable iff (!trst_n)
    (dr_sel == DR_BYP && state == S_CAP_DR) |=> !byp_q); // R5
endmodule

// File: tb/tb_scan_port_top.sv
module tb_scan_port_top;
  localparam int CLK_PERIOD = 100;
  localparam int N = 48;
  localparam logic [31:0] ID_EXP = 32'h1A2B_3C4F;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, out_enable;
  logic [N-1:0] pin_capture = '0;
  logic [N-1:0] preload_out;
  int nchk = 0, nerr = 0;

  scan_port_top dut (.tck, .trst_n, .tms, .tdi, .tdo, .tdo_oe,
                     .pin_capture, .preload_out, .out_enable);

  always #(CLK_PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset();
    chk("R2 reset preload", 64'(preload_out), 64'(48'h8000_0000_0000));
    chk("R11 reset out_enable", 64'(out_enable), 64'd1);
    chk("R12 tdo_oe idle", 64'(tdo_oe), 64'd0);
  endtask

  task automatic t_idcode();
    logic [63:0] d;
    scan_dr(64'h0, 32, d);
    chk("R3 idcode word", d[31:0], 64'(ID_EXP));
    chk("R12 tdo_oe after shift", 64'(tdo_oe), 64'd0);
  endtask

  task automatic t_bypass(input logic [2:0] op, input string req);
    logic [2:0] c; logic [63:0] d;
    load_ir(op, c);
    chk("R4 ir capture", 64'(c), 64'd1);
    scan_dr(64'hD, 4, d);
    chk(req, d[3:0], 64'b1010);
  endtask

  task automatic t_sample();
    logic [2:0] c; logic [63:0] d;
    pin_capture = 48'hA5C3_0F96_5AE1;
    load_ir(3'b100, c);
    scan_dr(64'(48'h3C5A_9E71_0B2D), N, d);
    chk("R7 sample snapshot", d[N-1:0], 64'(48'hA5C3_0F96_5AE1));
    chk("R8 preload update", 64'(preload_out), 64'(48'h3C5A_9E71_0B2D));
    chk("R11 sample out_enable", 64'(out_enable), 64'd1);
  endtask

  task automatic t_extest();
    logic [2:0] c; logic [63:0] d;
    load_ir(3'b000, c);
    chk("R9 extest gate low", 64'(out_enable), 64'd0);
    pin_capture = 48'h1234_5678_9ABC;
    scan_dr(64'(48'h8123_4567_89AB), N, d);
    chk("R7 extest capture", d[N-1:0], 64'(48'h1234_5678_9ABC));
    chk("R8 extest update", 64'(preload_out), 64'(48'h8123_4567_89AB));
    chk("R9 extest gate high", 64'(out_enable), 64'd1);
  endtask

  task automatic t_samplez();
    logic [2:0] c; logic [63:0] d;
    load_ir(3'b010, c);
    chk("R10 samplez hi-z", 64'(out_enable), 64'd0);
    pin_capture = 48'h0F0F_F0F0_3355;
    scan_dr(64'h5555, N, d);
    chk("R7 samplez capture", d[N-1:0], 64'(48'h0F0F_F0F0_3355));
    chk("R8 samplez no update", 64'(preload_out), 64'(48'h8123_4567_89AB));
    chk("R10 samplez still hi-z", 64'(out_enable), 64'd0);
    load_ir(3'b111, c);
    chk("R11 bypass restores enable", 64'(out_enable), 64'd1);
  endtask

  task automatic t_tlr();
    logic [2:0] c; logic [63:0] d;
    load_ir(3'b000, c);
    scan_dr(64'(48'h3C5A_9E71_0B2D), N, d);
    chk("R9 extest cell cleared", 64'(out_enable), 64'd0);
    tms_reset();
    chk("R1 R2 tms reset preload", 64'(preload_out), 64'(48'h8000_0000_0000));
    chk("R2 tms reset out_enable", 64'(out_enable), 64'd1);
    scan_dr(64'h0, 32, d);
    chk("R1 R2 idcode after tms reset", d[31:0], 64'(ID_EXP));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 7);
    t_reset();
    trst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    t_reset();
    t_idcode();
    t_bypass(3'b111, "R5 bypass delay");
    t_bypass(3'b101, "R6 reserved 101");
    t_bypass(3'b011, "R6 reserved 011");
    t_sample();
    t_extest();
    t_samplez();
    t_tlr();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule